// File: doc/BRIEF.md
# Bit I/O Port with Handshake Status Pins

This block is a general-purpose parallel port set to bit-level I/O. Each of its pins is an input or an output, chosen by a direction bit. Software writes an output value into a single-buffered data latch and reads the port back over a small synchronous register bus. A read returns the live pin level for input pins and the latched value for output pins. This suits boards where a handful of unrelated signals must be driven or watched one bit at a time.

The port has two handshake pins. They move no data; they only record events. The first is always an edge-detecting status input. The second has three personalities: an independent edge status input, an output held at its negated level, or an output held at its asserted level. Each handshake pin has a sense bit that says which level counts as asserted. Edge status bits are cleared three ways: by reset, by writing a one to the bit, and for as long as the pair enable bit is low.

Register map. The bus address is 2 bits wide and the data is 8 bits wide.

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit0 pair enable; bit1 first pin sense; bit2 second pin sense; bits[4:3] second pin mode. Bits 7:5 read as 0. |
| 1 | Direction | One bit per pin; 1 = output. |
| 2 | Data | Write sets the latch; read returns the per-bit mix described in R4. |
| 3 | Status | bit0 first pin status; bit1 second pin status; write-one-to-clear. |

For each sense bit, 1 means high is asserted, so the active edge is rising. A 0 means low is asserted, so the active edge is falling.

Second pin modes, from the value in bits[4:3]:

| bits[4:3] | Second pin behaviour |
|---|---|
| 0x | Edge status input |
| 10 | Output held negated |
| 11 | Output held asserted |

Read data is registered. It appears one clock after the address is presented.

Top module: `bio_port`

## Requirements
- R1: After reset, the Control, Direction, Data and Status registers all read 0, and `port_oe` and `hs2_oe` are 0.
- R2: A write to Data (address 2) always updates the latch, whatever the direction bits are. `port_out` shows the latch one clock after the write.
- R3: `port_oe[i]` equals Direction bit i one clock after Direction (address 1) is written, so a pin is driven only when its bit is 1.
- R4: A Data read returns `port_in[i]` for bits whose direction is 0 and the latched bit for bits whose direction is 1. The value is sampled in the cycle the address is presented.
- R5: When the pair is enabled, an asserted edge on `hs1_in` sets Status bit0. Sense bit1 of Control selects the edge: 1 picks rising, 0 picks falling. The opposite edge does nothing.
- R6: Writing a 1 to a Status bit clears it; writing a 0 leaves it unchanged.
- R7: While Control bit0 is 0, both status bits stay 0 and edges on the handshake inputs are not recorded.
- R8: In mode 0x, `hs2_in` sets Status bit1 on its asserted edge, selected by sense bit2. This works independently of `hs1_in`, and `hs2_oe` is 0.
- R9: In modes 10 and 11, `hs2_oe` is 1 and Status bit1 stays 0. `hs2_out` equals the inverse of sense bit2 in mode 10 and equals sense bit2 in mode 11.
- R10: Control bits[4:0] and all Direction bits read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| port_in | input | 8 | Pin levels seen from the pads |
| port_out | output | 8 | Latched output data to the pads |
| port_oe | output | 8 | Per-pin output enable |
| hs1_in | input | 1 | First handshake pin (input only) |
| hs2_in | input | 1 | Second handshake pin, input side |
| hs2_out | output | 1 | Second handshake pin, output level |
| hs2_oe | output | 1 | Second handshake pin, output enable |

## Verification
The checker enforces several rules on every clock:
- Direction and Data writes reach `port_oe` and `port_out` one clock later.
- Both status bits are held at zero whenever the pair is disabled.
- Status bit1 is forced to zero and `hs2_oe` is raised in the two output modes.

Some behaviours only the bench scenarios can show:
- Which edge polarity sets a status bit.
- That the opposite edge is ignored.
- That a write-one-to-clear leaves the other bit alone.
- The per-bit mix of live pins and latched data on a Data read.

These are checked against a bench model under random direction, data and pin patterns.

// File: rtl/bio_port_pkg.sv
package bio_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;
  localparam int NUM_HS = 2;

  typedef enum logic [1:0] {
    HS2_EDGE0 = 2'b00,
    HS2_EDGE1 = 2'b01,
    HS2_NEG   = 2'b10,
    HS2_ASRT  = 2'b11
  } hs2_mode_t;

  typedef struct packed {
    hs2_mode_t mode;
    logic      sense2;
    logic      sense1;
    logic      enable;
  } ctrl_t;
endpackage

// File: rtl/bio_hs_status.sv
module bio_hs_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic sense,
  input  logic enable,
  input  logic force_off,
  input  logic clr,
  output logic status
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    if (sense) edge_hit = sync_q[SYNC_STAGES-1] & ~prev_q;
    else       edge_hit = ~sync_q[SYNC_STAGES-1] & prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b0;
    else     status <= enable & ~force_off & (edge_hit | (status & ~clr));
  end
endmodule

// File: rtl/bio_data_regs.sv
module bio_data_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic             wr_data,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] read_mix
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_data) data_q <= wdata;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_mix
    assign read_mix[i] = dir_q[i] ? data_q[i] : pin_in[i];
  end
endmodule

// File: rtl/bio_hs2_drive.sv
module bio_hs2_drive (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       sense,
  output logic       out_level,
  output logic       out_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_level <= 1'b0;
      out_en    <= 1'b0;
    end else begin
      out_en    <= mode[1];
      out_level <= mode[1] & ~(mode[0] ^ sense);
    end
  end
endmodule

// File: rtl/bio_port.sv
module bio_port
  import bio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  port_in,
  output logic [WIDTH-1:0]  port_out,
  output logic [WIDTH-1:0]  port_oe,
  input  logic              hs1_in,
  input  logic              hs2_in,
  output logic              hs2_out,
  output logic              hs2_oe
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic [WIDTH-1:0] dir_q, data_q, read_mix;
  logic [NUM_HS-1:0] stat_q, pins, senses, forces, clrs;
  logic wr_ctrl, wr_stat;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  bio_data_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst),
    .wr_dir(bus_wr && (bus_addr == A_DIR)),
    .wr_data(bus_wr && (bus_addr == A_DATA)),
    .wdata(bus_wdata), .pin_in(port_in),
    .dir_q(dir_q), .data_q(data_q), .read_mix(read_mix)
  );

  assign pins   = {hs2_in, hs1_in};
  assign senses = {ctrl_q.sense2, ctrl_q.sense1};
  assign forces = {ctrl_q.mode[1], 1'b0};
  assign clrs   = wr_stat ? bus_wdata[NUM_HS-1:0] : '0;

  for (genvar h = 0; h < NUM_HS; h++) begin : g_hs
    bio_hs_status u_hs (
      .clk(clk), .rst(rst), .pin(pins[h]), .sense(senses[h]),
      .enable(ctrl_q.enable), .force_off(forces[h]), .clr(clrs[h]),
      .status(stat_q[h])
    );
  end

  bio_hs2_drive u_drv (
    .clk(clk), .rst(rst), .mode(ctrl_q.mode), .sense(ctrl_q.sense2),
    .out_level(hs2_out), .out_en(hs2_oe)
  );

  assign port_out = data_q;
  assign port_oe  = dir_q;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= WIDTH'(ctrl_q);
        A_DIR:   bus_rdata <= dir_q;
        A_DATA:  bus_rdata <= read_mix;
        default: bus_rdata <= WIDTH'(stat_q);
      endcase
    end
  end
endmodule

module bio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] port_out,
  input logic [WIDTH-1:0] port_oe,
  input logic             hs_en,
  input logic             mode_out,
  input logic [1:0]       stat,
  input logic             hs2_oe
);
  assert_dir_to_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1) |=> (port_oe == $past(bus_wdata)));

  assert_data_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2) |=> (port_out == $past(bus_wdata)));

  assert_disabled_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !hs_en |=> (stat == 2'b00));

  assert_outmode_stat_R9: assert property (@(posedge clk) disable iff (rst)
    mode_out |=> !stat[1]);

  assert_outmode_oe_R9: assert property (@(posedge clk) disable iff (rst)
    mode_out |=> hs2_oe);
endmodule

bind bio_port bio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .port_out(port_out), .port_oe(port_oe),
  .hs_en(ctrl_q.enable), .mode_out(ctrl_q.mode[1]), .stat(stat_q),
  .hs2_oe(hs2_oe)
);

// File: tb/test_bio_port.sv
module test_bio_port;
  localparam int PERIOD = 10;
  logic clk = 0, rst = 1;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, port_in = 0, port_out, port_oe;
  logic hs1_in = 0, hs2_in = 0, hs2_out, hs2_oe;
  int total = 0, bad = 0;
  logic [7:0] m_dir = 0, m_data = 0;

  always #(PERIOD/2) clk = ~clk;

  bio_port i_bio_port (.*);

  function automatic logic [7:0] exp_mix(logic [7:0] d, logic [7:0] q, logic [7:0] p);
    return (d & q) | (~d & p);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (a == 1) m_dir = d;
    if (a == 2) m_data = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(17));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 oe", port_oe, 8'h00);
    chk("R1 hs2_oe", {7'b0, hs2_oe}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      port_in = 8'h00;
      rd(2'(a), r); chk("R1 reg", r, 8'h00);
    end
    // R2 data latched on input pins, R10 readback
    wr(2, 8'hA5);
    chk("R2 latch with dir 0", port_out, 8'hA5);
    port_in = 8'h3C; rd(2, r); chk("R4 all inputs", r, 8'h3C);
    wr(1, 8'hF0); chk("R3 oe", port_oe, 8'hF0);
    rd(1, r); chk("R10 dir readback", r, 8'hF0);
    rd(2, r); chk("R4 mixed", r, exp_mix(8'hF0, 8'hA5, 8'h3C));
    wr(0, 8'h1B); rd(0, r); chk("R10 ctrl readback", r, 8'h1B);
    wr(0, 8'hFF); rd(0, r); chk("R10 ctrl upper bits", r, 8'h1F);
    // random R2 R3 R4
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(1, 0)) wr(1, 8'($urandom));
      if ($urandom_range(1, 0)) wr(2, 8'($urandom));
      port_in = 8'($urandom);
      chk("R3 random oe", port_oe, m_dir);
      chk("R2 random out", port_out, m_data);
      rd(2, r); chk("R4 random read", r, exp_mix(m_dir, m_data, port_in));
    end
    // R5 rising edge sense
    wr(0, 8'h07); idle(4);
    hs1_in = 1; idle(5);
    rd(3, r); chk("R5 rising sets bit0", r, 8'h01);
    wr(3, 8'h02); rd(3, r); chk("R6 write0 keeps bit0", r, 8'h01);
    wr(3, 8'h01); rd(3, r); chk("R6 w1c clears", r, 8'h00);
    hs1_in = 0; idle(5);
    rd(3, r); chk("R5 falling ignored", r, 8'h00);
    // R5 falling sense
    wr(0, 8'h05); idle(3);
    hs1_in = 1; idle(5);
    rd(3, r); chk("R5 rising ignored at low sense", r, 8'h00);
    hs1_in = 0; idle(5);
    rd(3, r); chk("R5 falling sets at low sense", r, 8'h01);
    // R8 second pin edge input, independent
    hs2_in = 1; idle(5);
    rd(3, r); chk("R8 hs2 edge", r, 8'h03);
    chk("R8 hs2_oe off", {7'b0, hs2_oe}, 8'h00);
    wr(3, 8'h02); rd(3, r); chk("R6 clear bit1 only", r, 8'h01);
    // R7 disable clears and blocks
    wr(0, 8'h04); rd(3, r); chk("R7 disable clears", r, 8'h00);
    hs2_in = 0; hs1_in = 1; idle(5); hs1_in = 0; idle(5);
    rd(3, r); chk("R7 edges ignored", r, 8'h00);
    // R9 output modes
    wr(0, 8'h15); idle(1);
    chk("R9 neg sense1", {6'b0, hs2_oe, hs2_out}, 8'h02);
    wr(0, 8'h1D); idle(1);
    chk("R9 asrt sense1", {6'b0, hs2_oe, hs2_out}, 8'h03);
    wr(0, 8'h19); idle(1);
    chk("R9 asrt sense0", {6'b0, hs2_oe, hs2_out}, 8'h02);
    wr(0, 8'h11); idle(1);
    chk("R9 neg sense0", {6'b0, hs2_oe, hs2_out}, 8'h03);
    hs2_in = 1; idle(5); hs2_in = 0; idle(5);
    rd(3, r); chk("R9 status bit1 held 0", r, 8'h00);
    wr(0, 8'h01); idle(1);
    chk("R8 back to input", {6'b0, hs2_oe, hs2_out}, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule